// File: doc/BRIEF.md
# Event-Combination Histogram Monitor

This monitor turns a small set of chosen event lines into a histogram of their coincidences. Each bank has its own map that picks one raw event input for every address bit. The selected bits, taken together, form a word address into that bank's counter memory. While counting is active, both banks add one to the addressed word in every cycle. A cycle in which no selected event fires is counted too, at address zero. Because every combination of events has its own counter, the host can recover joint statistics and not just per-event totals.

The host first stops counting with the global enable. It then reads any counter of either bank through a one-cycle-latency read port, or starts a sweep that writes zero to every counter. A small first-in first-out trace buffer records a data word for each memory operation flagged while counting is active. The host drains it one entry at a time. Counters saturate at their maximum value. The read-modify-write pipeline forwards its last write, so consecutive hits on one counter are all kept.

Top module: `evt_histo_mon`

## Requirements
- R1: After reset, host_rvalid, clr_busy and trc_valid are low, and every bank maps address bit i to event input i. Counter contents are undefined until the first clear sweep.
- R2: In every cycle with count_en high and no sweep running, each bank forms an address whose bit i is the event input selected for its slot i, and adds one to the counter at that address.
- R3: Hits on the same address in consecutive cycles are each counted: N cycles on one address raise that counter by N.
- R4: A counter that holds all ones keeps that value on further hits. It never wraps to zero.
- R5: A pulse on cfg_we sets slot cfg_slot of bank cfg_bank (0 or 1) to event input cfg_src. An event sampled in the same cycle still uses the old mapping; events from the next cycle use the new one.
- R6: host_rd is accepted only when count_en is low and no sweep is running. One cycle later host_rvalid is high for one cycle and host_rdata holds the counter at host_addr of bank host_bank, including any increment still in flight.
- R7: clr_go, seen while count_en is low and no sweep is running, raises clr_busy from the next cycle for exactly 2^ADDR_W cycles. The sweep zeroes every counter of both banks. Events and host reads presented during the sweep are ignored.
- R8: op_valid in a counting cycle pushes op_data into the trace buffer. trc_valid shows that an entry is present, trc_data shows the oldest entry, and trc_pop removes it, in arrival order.
- R9: A push into a full trace buffer is dropped. op_valid while count_en is low records nothing.
- R10: While count_en is low, no counter changes, whatever the event inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | EVT_W | Raw event lines |
| count_en | input | 1 | Global counting enable |
| cfg_we | input | 1 | Event-select write strobe |
| cfg_bank | input | 1 | Bank written by cfg_we |
| cfg_slot | input | SLOT_W | Address bit (slot) being mapped |
| cfg_src | input | SRC_W | Event input index assigned to the slot |
| host_rd | input | 1 | Counter read request |
| host_bank | input | 1 | Bank to read |
| host_addr | input | ADDR_W | Counter address to read |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | CNT_W | Read data |
| clr_go | input | 1 | Start clear sweep |
| clr_busy | output | 1 | Clear sweep running |
| op_valid | input | 1 | Memory operation present |
| op_data | input | TRC_W | Word recorded for the operation |
| trc_pop | input | 1 | Remove oldest trace entry |
| trc_valid | output | 1 | Trace buffer not empty |
| trc_data | output | TRC_W | Oldest trace entry |

## Verification
The assertions check the following on every cycle:
- A counting write and a sweep write never land on a bank in the same cycle.
- A counting write never stores zero, so counters cannot wrap.
- A sweep starts the cycle after it is accepted and ends after its last address.
- Read data only appears after an accepted read.
- A full trace buffer does not grow.

Only the bench's scenarios can show the rest:
- Histogram contents under varied event patterns and remapped selects.
- Exact totals for long runs on one address.
- The boundary between old and new mapping on a select write.
- That frozen cycles and swept memory leave the expected values.

// File: rtl/evt_histo_pkg.sv
package evt_histo_pkg;

  // Clear sweep sequencer states
  typedef enum logic [0:0] {
    SWP_IDLE = 1'b0,
    SWP_RUN  = 1'b1
  } swp_state_e;

  localparam int NBANK = 2;

endpackage

// File: rtl/evt_histo_map.sv
// Per-bank event-select registers and address formation.
module evt_histo_map #(
  parameter int EVT_W  = 16,
  parameter int ADDR_W = 6,
  parameter int SRC_W  = 4,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [SRC_W-1:0]  wr_src,
  output logic [ADDR_W-1:0] addr
);

  logic [SRC_W-1:0] sel_q [ADDR_W];
  logic [SRC_W-1:0] sel_d [ADDR_W];
  logic             slot_ok;

  assign slot_ok = wr_en && (int'(wr_slot) < ADDR_W);

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      sel_d[i] = sel_q[i];
      if (slot_ok && (int'(wr_slot) == i)) sel_d[i] = wr_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ADDR_W; i++) sel_q[i] <= SRC_W'(i % EVT_W);
    end else if (slot_ok) begin
      for (int i = 0; i < ADDR_W; i++) sel_q[i] <= sel_d[i];
    end
  end

  for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
    assign addr[g] = (int'(sel_q[g]) < EVT_W) ? evt_in[sel_q[g]] : 1'b0;
  end

endmodule

// File: rtl/evt_histo_bank.sv
// One counter bank: synchronous read, saturating increment, write with
// one-entry forwarding of the previous write.
module evt_histo_bank #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_v,
  input  logic [ADDR_W-1:0] cnt_addr,
  input  logic              host_v,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              clr_v,
  input  logic [ADDR_W-1:0] clr_addr,
  output logic [CNT_W-1:0]  rd_data
);

  logic [CNT_W-1:0]  mem [DEPTH];

  logic              rd_en;
  logic [ADDR_W-1:0] raddr;
  logic [CNT_W-1:0]  rdata_q;
  logic [ADDR_W-1:0] ra1_q;
  logic              v1_q;

  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [CNT_W-1:0]  wdata;
  logic              we2_q;
  logic [ADDR_W-1:0] a2_q;
  logic [CNT_W-1:0]  wd2_q;

  logic [CNT_W-1:0]  base;
  logic [CNT_W-1:0]  bumped;

  // read stage
  assign rd_en = cnt_v || host_v;
  assign raddr = cnt_v ? cnt_addr : host_addr;

  always_ff @(posedge clk) begin
    if (rd_en) rdata_q <= mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra1_q <= '0;
      v1_q  <= 1'b0;
    end else begin
      v1_q <= cnt_v;
      if (rd_en) ra1_q <= raddr;
    end
  end

  // modify stage with forwarding of the write made one cycle earlier
  always_comb begin
    base   = (we2_q && (a2_q == ra1_q)) ? wd2_q : rdata_q;
    bumped = (&base) ? base : base + CNT_W'(1);
  end

  assign rd_data = base;

  // write stage
  always_comb begin
    we    = clr_v || v1_q;
    waddr = clr_v ? clr_addr : ra1_q;
    wdata = clr_v ? '0 : bumped;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we2_q <= 1'b0;
      a2_q  <= '0;
      wd2_q <= '0;
    end else begin
      we2_q <= we;
      if (we) begin
        a2_q  <= waddr;
        wd2_q <= wdata;
      end
    end
  end

  // R7: sweep writes and counting writes are never issued together
  assert_one_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_v && v1_q));

  // R4: a counting write never stores zero (no wrap)
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |-> (wdata != '0));

endmodule

// File: rtl/evt_histo_trace.sv
// Show-ahead FIFO for memory-operation trace words.
module evt_histo_trace #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = PTR_W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] head
);

  logic [W-1:0]     buf_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, empty, push_ok, pop_ok;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_ok) wp_d = (int'(wp_q) == DEPTH - 1) ? '0 : wp_q + PTR_W'(1);
    if (pop_ok)  rp_d = (int'(rp_q) == DEPTH - 1) ? '0 : rp_q + PTR_W'(1);
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) buf_q[wp_q] <= push_data;
  end

  assign valid = !empty;
  assign head  = buf_q[rp_q];

  // R9: a full buffer does not take a push
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> $stable(cnt_q));

  // R8: an empty buffer stays empty without a push
  assert_empty_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> (cnt_q == '0));

endmodule

// File: rtl/evt_histo_mon.sv
module evt_histo_mon
  import evt_histo_pkg::*;
#(
  parameter int EVT_W     = 16,
  parameter int ADDR_W    = 6,
  parameter int CNT_W     = 32,
  parameter int TRACE_EN  = 1,
  parameter int TRC_DEPTH = 16,
  parameter int TRC_W     = 32,
  localparam int SRC_W  = (EVT_W > 1) ? $clog2(EVT_W) : 1,
  localparam int SLOT_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic              count_en,
  input  logic              cfg_we,
  input  logic              cfg_bank,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [SRC_W-1:0]  cfg_src,
  input  logic              host_rd,
  input  logic              host_bank,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              host_rvalid,
  output logic [CNT_W-1:0]  host_rdata,
  input  logic              clr_go,
  output logic              clr_busy,
  input  logic              op_valid,
  input  logic [TRC_W-1:0]  op_data,
  input  logic              trc_pop,
  output logic              trc_valid,
  output logic [TRC_W-1:0]  trc_data
);

  // clear sweep sequencer
  swp_state_e        swp_q, swp_d;
  logic [ADDR_W-1:0] swp_addr_q, swp_addr_d;
  logic              clr_accept;

  assign clr_busy   = (swp_q == SWP_RUN);
  assign clr_accept = clr_go && !count_en && !clr_busy;

  always_comb begin
    swp_d      = swp_q;
    swp_addr_d = swp_addr_q;
    case (swp_q)
      SWP_IDLE: if (clr_accept) begin
        swp_d      = SWP_RUN;
        swp_addr_d = '0;
      end
      SWP_RUN: begin
        swp_addr_d = swp_addr_q + ADDR_W'(1);
        if (swp_addr_q == '1) swp_d = SWP_IDLE;
      end
      default: swp_d = SWP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swp_q      <= SWP_IDLE;
      swp_addr_q <= '0;
    end else begin
      swp_q      <= swp_d;
      swp_addr_q <= swp_addr_d;
    end
  end

  // gating
  logic count_v, host_v;
  assign count_v = count_en && !clr_busy;
  assign host_v  = host_rd && !count_en && !clr_busy;

  // banks
  logic [ADDR_W-1:0] bank_addr [NBANK];
  logic [CNT_W-1:0]  bank_rd   [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    evt_histo_map #(
      .EVT_W (EVT_W),
      .ADDR_W(ADDR_W),
      .SRC_W (SRC_W),
      .SLOT_W(SLOT_W)
    ) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_in (evt_in),
      .wr_en  (cfg_we && (int'(cfg_bank) == b)),
      .wr_slot(cfg_slot),
      .wr_src (cfg_src),
      .addr   (bank_addr[b])
    );

    evt_histo_bank #(
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_v    (count_v),
      .cnt_addr (bank_addr[b]),
      .host_v   (host_v && (int'(host_bank) == b)),
      .host_addr(host_addr),
      .clr_v    (clr_busy),
      .clr_addr (swp_addr_q),
      .rd_data  (bank_rd[b])
    );
  end

  // host read response
  logic rvalid_q, hbank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      hbank_q  <= 1'b0;
    end else begin
      rvalid_q <= host_v;
      if (host_v) hbank_q <= host_bank;
    end
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = bank_rd[hbank_q];

  // trace buffer
  if (TRACE_EN != 0) begin : g_trace
    evt_histo_trace #(
      .W    (TRC_W),
      .DEPTH(TRC_DEPTH)
    ) u_trace (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (op_valid && count_v),
      .push_data(op_data),
      .pop      (trc_pop),
      .valid    (trc_valid),
      .head     (trc_data)
    );
  end else begin : g_no_trace
    assign trc_valid = 1'b0;
    assign trc_data  = '0;
  end

  // R7: an accepted clear starts the sweep on the next cycle
  assert_sweep_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_accept |=> clr_busy);

  // R7: the sweep ends after its last address
  assert_sweep_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_busy && (swp_addr_q == '1)) |=> !clr_busy);

  // R6: read data appears only after an accepted read
  assert_rvalid_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_rd && !count_en && !clr_busy));

endmodule

// File: tb/evt_histo_mon_tb.sv
`timescale 1ns/1ps
module evt_histo_mon_tb;

  localparam int EVT_W = 8, ADDR_W = 4, CNT_W = 6, TRC_DEPTH = 4, TRC_W = 8;
  localparam int SRC_W = 3, SLOT_W = 2, DEPTH = 1 << ADDR_W, CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [EVT_W-1:0] evt_in;
  logic count_en, cfg_we, cfg_bank, host_rd, host_bank, clr_go, op_valid, trc_pop;
  logic [SLOT_W-1:0] cfg_slot;
  logic [SRC_W-1:0] cfg_src;
  logic [ADDR_W-1:0] host_addr;
  logic host_rvalid, clr_busy, trc_valid;
  logic [CNT_W-1:0] host_rdata;
  logic [TRC_W-1:0] op_data, trc_data;

  always #2.5 clk = ~clk;

  evt_histo_mon #(
    .EVT_W(EVT_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .TRACE_EN(1), .TRC_DEPTH(TRC_DEPTH), .TRC_W(TRC_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .count_en(count_en),
    .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_slot(cfg_slot), .cfg_src(cfg_src),
    .host_rd(host_rd), .host_bank(host_bank), .host_addr(host_addr),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .clr_go(clr_go), .clr_busy(clr_busy),
    .op_valid(op_valid), .op_data(op_data),
    .trc_pop(trc_pop), .trc_valid(trc_valid), .trc_data(trc_data)
  );

  int checks = 0, fails = 0;
  int model [2][DEPTH];
  int sel   [2][ADDR_W];
  int    exp_val [$];
  string exp_tag [$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int addr_of(int b, logic [EVT_W-1:0] e);
    int a = 0;
    for (int i = 0; i < ADDR_W; i++) if (e[sel[b][i]]) a |= (1 << i);
    return a;
  endfunction

  function automatic void model_hit(logic [EVT_W-1:0] e);
    for (int b = 0; b < 2; b++) begin
      int a = addr_of(b, e);
      if (model[b][a] < CMAX) model[b][a]++;
    end
  endfunction

  // monitor: compares each read response with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_val.size() == 0) chk("R6 unexpected rvalid", 1, 0);
      else chk(exp_tag.pop_front(), int'(host_rdata), exp_val.pop_front());
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle_inputs();
    count_en = 0; cfg_we = 0; host_rd = 0; clr_go = 0; op_valid = 0; trc_pop = 0;
  endtask

  task automatic count_cycle(logic [EVT_W-1:0] e, logic opv, logic [TRC_W-1:0] opd);
    idle_inputs();
    count_en = 1; evt_in = e; op_valid = opv; op_data = opd;
    model_hit(e);
    step();
    idle_inputs();
  endtask

  task automatic set_sel(int b, int slot, int src, logic cnt, logic [EVT_W-1:0] e);
    idle_inputs();
    cfg_we = 1; cfg_bank = b[0]; cfg_slot = SLOT_W'(slot); cfg_src = SRC_W'(src);
    count_en = cnt; evt_in = e;
    if (cnt) model_hit(e);         // same-cycle event uses the old mapping (R5)
    sel[b][slot] = src;
    step();
    idle_inputs();
  endtask

  // driver: issue a read and push the expected value
  task automatic host_read(int b, int a, string tag);
    idle_inputs();
    host_rd = 1; host_bank = b[0]; host_addr = ADDR_W'(a);
    exp_val.push_back(model[b][a]);
    exp_tag.push_back($sformatf("%s bank%0d addr%0d", tag, b, a));
    step();
    idle_inputs();
  endtask

  task automatic read_all(string tag);
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < DEPTH; a++) host_read(b, a, tag);
    step(); step();
    chk({tag, " all reads answered"}, exp_val.size(), 0);
  endtask

  task automatic clear_sweep();
    idle_inputs();
    clr_go = 1;
    step();
    for (int i = 0; i < DEPTH; i++) begin
      clr_go = 0;
      count_en = 1; evt_in = EVT_W'(8'hFF); host_rd = 1;   // ignored during sweep
      @(negedge clk);
      chk("R7 busy during sweep", int'(clr_busy), 1);
      chk("R7 read ignored in sweep", int'(host_rvalid), 0);
      step();
    end
    idle_inputs();
    chk("R7 busy ends", int'(clr_busy), 0);
    for (int b = 0; b < 2; b++) for (int a = 0; a < DEPTH; a++) model[b][a] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [EVT_W-1:0] pat [10];
    pat = '{8'h01, 8'h01, 8'h01, 8'h13, 8'hA5, 8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h01};
    rst_n = 0; evt_in = '0; cfg_bank = 0; cfg_slot = '0; cfg_src = '0;
    host_bank = 0; host_addr = '0; op_data = '0;
    idle_inputs();
    for (int b = 0; b < 2; b++) for (int i = 0; i < ADDR_W; i++) sel[b][i] = i;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 rvalid after reset", int'(host_rvalid), 0);
    chk("R1 busy after reset", int'(clr_busy), 0);
    chk("R1 trace empty after reset", int'(trc_valid), 0);
    step();

    clear_sweep();
    read_all("R7 zero after clear");

    // bank 1: slot i <- event 7-i
    for (int i = 0; i < ADDR_W; i++) set_sel(1, i, 7 - i, 1'b0, '0);

    // R2/R3: mixed patterns including repeated addresses; identity map on bank 0 (R1)
    for (int k = 0; k < 10; k++) count_cycle(pat[k], 1'b0, '0);
    // R5: select write in a counting cycle
    set_sel(0, 0, 7, 1'b1, 8'h81);
    count_cycle(8'h80, 1'b0, '0);
    // R10: frozen cycles with toggling events
    for (int k = 0; k < 3; k++) begin
      idle_inputs(); evt_in = EVT_W'(8'h0F ^ k); step();
    end
    host_read(0, addr_of(0, 8'h80), "R6 in-flight increment");
    read_all("R2 R3 R5 R10 histogram");

    // R4: saturation
    clear_sweep();
    for (int k = 0; k < CMAX + 7; k++) count_cycle(8'h05, 1'b0, '0);
    host_read(0, addr_of(0, 8'h05), "R4 saturate");
    host_read(1, addr_of(1, 8'h05), "R4 saturate");
    step(); step();

    // R8/R9: trace
    for (int k = 1; k <= 6; k++) count_cycle(8'h00, 1'b1, TRC_W'(k));
    idle_inputs(); op_valid = 1; op_data = TRC_W'(99); step(); idle_inputs();
    for (int k = 1; k <= TRC_DEPTH; k++) begin
      @(negedge clk);
      chk("R8 trace valid", int'(trc_valid), 1);
      chk("R8 R9 trace order", int'(trc_data), k);
      step();
      trc_pop = 1; step(); trc_pop = 0;
    end
    @(negedge clk);
    chk("R9 trace drained", int'(trc_valid), 0);
    step();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule